// File: doc/BRIEF.md
# Nine-Tap Bit-Serial Lookup FIR Filter

This block is a nine-tap finite impulse response filter that forms its output without a single multiplier. Each accepted signed sample enters a tap history. A parallel-to-serial copy of the nine most recent samples is then taken. Over the following clock cycles, one bit of equal weight is taken from every tap. Together these nine bits address precomputed tables of coefficient sums. A scaling accumulator adds each table word at the weight of its bit position. It subtracts the word for the sign position.

The two coefficient sets are fixed: one is low-pass and one is high-pass. A select input picks the set for each sample, and the set is captured when the sample is accepted. The nine-bit lookup is split into a five-address-bit table and a four-address-bit table, and their outputs are added. The result is the full-precision dot product. It is presented with a one-cycle valid pulse and held until the next result.

Top module: `da_fir9`

## Requirements
- R1: When `out_valid` is high, `out_y` equals the sum over k = 0..8 of c[k]·x[n−k]. Here x[n] is the newest accepted sample, x[n−k] is the sample accepted k acceptances earlier, and a position never filled since reset counts as 0.
- R2: Samples are 8-bit two's complement. The bit-7 weight is −128, so an input of −128 contributes −128·c[k].
- R3: With `hp_sel` = 0 the coefficients c[0..8] are 3, 10, 26, 44, 52, 44, 26, 10, 3. With `hp_sel` = 1 they are 3, −10, 26, −44, 52, −44, 26, −10, 3.
- R4: A sample is accepted on a rising edge where `in_valid` is high and no computation is running. `out_valid` is then high for exactly one cycle, in the cycle that follows the 8th rising edge after the accepting edge.
- R5: `in_valid` during the 8 cycles of a running computation has no effect. That sample never enters the tap history.
- R6: Synchronous active-high `rst` clears the tap history, `out_y` and `out_valid`.
- R7: `out_y` keeps its value in every cycle where `out_valid` is low.
- R8: `hp_sel` is taken at the accepting edge. Changing it while a computation runs does not alter that result.
- R9: The result never overflows. All-extreme inputs give exact values: nine −128 samples at low-pass give −27904, nine 127 samples give 27686, and the sign-matched high-pass pattern gives 27794.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered this cycle |
| in_sample | input | 8 | Signed input sample |
| hp_sel | input | 1 | Coefficient set: 0 low-pass, 1 high-pass |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_y | output | 22 | Signed full-precision filter output |

## Verification
Two situations are the hardest to reach from the ports. The first is an offered sample that must be dropped. The second is a coefficient select that changes after the set has been captured. Both exist only inside the eight-cycle window of a running computation. The stimulus therefore drives `in_valid` with a distinctive value, or toggles `hp_sel`, on cycles inside that window. It then sends an impulse that follows, whose result exposes any leak into the history or any change of coefficients. Sign-bit handling is driven to its limits with runs of −128 and with a high-pass pattern whose signs match every coefficient.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    parameter int TAPS    = 9;
    parameter int DW      = 8;
    parameter int LO_BITS = 5;
    localparam int HI_BITS = TAPS - LO_BITS;
    localparam int CNT_W   = $clog2(DW);
    localparam int LUT_W   = 10 + $clog2(TAPS);
    localparam int ACC_W   = DW + LUT_W;

    typedef enum logic { SET_LOW = 1'b0, SET_HIGH = 1'b1 } coef_set_e;

    typedef logic signed [DW-1:0]    sample_t;
    typedef logic signed [LUT_W-1:0] lut_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] bit_idx;
        coef_set_e        set;
    } ctrl_t;

    // symmetric low-pass prototype; high-pass negates odd taps
    function automatic int coef_val(coef_set_e s, int k);
        int d;
        int base;
        d = (k > TAPS / 2) ? (TAPS - 1 - k) : k;
        case (d)
            0:       base = 3;
            1:       base = 10;
            2:       base = 26;
            3:       base = 44;
            default: base = 52;
        endcase
        if (s == SET_HIGH && (k % 2) == 1) base = -base;
        return base;
    endfunction

    function automatic lut_t lut_sum(coef_set_e s, int first, int nb, int addr);
        int acc;
        acc = 0;
        for (int i = 0; i < nb; i++)
            if (((addr >> i) & 1) != 0) acc += coef_val(s, first + i);
        return lut_t'(acc);
    endfunction

    function automatic int coef_abs_total(coef_set_e s);
        int t;
        t = 0;
        for (int k = 0; k < TAPS; k++) begin
            if (coef_val(s, k) < 0) t -= coef_val(s, k);
            else                    t += coef_val(s, k);
        end
        return t;
    endfunction

    localparam int PEAK = (2 ** (DW - 1)) * coef_abs_total(SET_LOW);

endpackage

// File: rtl/da_tap_store.sv
module da_tap_store
    import da_fir_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            shift,
    input  sample_t         din,
    output logic [TAPS-1:0] slice
);
    sample_t         hist_q [TAPS];
    logic [DW-1:0]   work_q [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TAPS; k++) begin
                hist_q[k] <= '0;
                work_q[k] <= '0;
            end
        end else if (load) begin
            hist_q[0] <= din;
            work_q[0] <= din;
            for (int k = 1; k < TAPS; k++) begin
                hist_q[k] <= hist_q[k-1];
                work_q[k] <= hist_q[k-1];
            end
        end else if (shift) begin
            for (int k = 0; k < TAPS; k++)
                work_q[k] <= work_q[k] >> 1;
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_slice
        assign slice[k] = work_q[k][0];
    end

endmodule

// File: rtl/da_rom.sv
module da_rom
    import da_fir_pkg::*;
#(
    parameter int FIRST = 0,
    parameter int NB    = 5
) (
    input  coef_set_e     set,
    input  logic [NB-1:0] addr,
    output lut_t          word
);
    lut_t tab [2][2**NB];

    for (genvar s = 0; s < 2; s++) begin : g_set
        for (genvar a = 0; a < 2**NB; a++) begin : g_word
            assign tab[s][a] = lut_sum(coef_set_e'(s), FIRST, NB, a);
        end
    end

    assign word = tab[set][addr];

endmodule

// File: rtl/da_scale_acc.sv
module da_scale_acc
    import da_fir_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    input  logic [CNT_W-1:0] bit_idx,
    input  lut_t             term,
    output logic             y_valid,
    output acc_t             y
);
    acc_t acc_q;
    acc_t ext;
    acc_t weighted;
    acc_t nxt;
    logic last;

    always_comb begin
        ext      = {{(ACC_W-LUT_W){term[LUT_W-1]}}, term};
        weighted = ext <<< bit_idx;
        last     = (bit_idx == CNT_W'(DW - 1));
        nxt      = last ? (acc_q - weighted) : (acc_q + weighted);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            y       <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= 1'b0;
            if (start) begin
                acc_q <= '0;
            end else if (step) begin
                acc_q <= nxt;
                if (last) begin
                    y       <= nxt;
                    y_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/da_fir9.sv
module da_fir9
    import da_fir_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_sample,
    input  logic             hp_sel,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_y
);
    ctrl_t           ctrl_q;
    logic            accept;
    logic            busy_w;
    logic [TAPS-1:0] slice;
    lut_t            lo_word;
    lut_t            hi_word;
    lut_t            term;
    acc_t            y_w;

    assign busy_w = ctrl_q.busy;
    assign accept = in_valid && !ctrl_q.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{busy: 1'b0, bit_idx: '0, set: SET_LOW};
        end else if (accept) begin
            ctrl_q <= '{busy: 1'b1, bit_idx: '0, set: coef_set_e'(hp_sel)};
        end else if (ctrl_q.busy) begin
            if (ctrl_q.bit_idx == CNT_W'(DW - 1)) ctrl_q.busy <= 1'b0;
            else                                 ctrl_q.bit_idx <= ctrl_q.bit_idx + 1'b1;
        end
    end

    da_tap_store u_taps (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .shift (ctrl_q.busy),
        .din   (sample_t'(in_sample)),
        .slice (slice)
    );

    da_rom #(.FIRST(0), .NB(LO_BITS)) u_rom_lo (
        .set  (ctrl_q.set),
        .addr (slice[LO_BITS-1:0]),
        .word (lo_word)
    );

    da_rom #(.FIRST(LO_BITS), .NB(HI_BITS)) u_rom_hi (
        .set  (ctrl_q.set),
        .addr (slice[TAPS-1:LO_BITS]),
        .word (hi_word)
    );

    assign term = lo_word + hi_word;

    da_scale_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .step    (ctrl_q.busy),
        .bit_idx (ctrl_q.bit_idx),
        .term    (term),
        .y_valid (out_valid),
        .y       (y_w)
    );

    assign out_y = y_w;

endmodule

// File: rtl/da_fir9_chk.sv
module da_fir9_chk
    import da_fir_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             busy,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_y
);
    int since_acc;

    always_ff @(posedge clk) begin
        if (rst)                   since_acc <= 1000;
        else if (in_valid && !busy) since_acc <= 0;
        else if (since_acc < 1000) since_acc <= since_acc + 1;
    end

    assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> since_acc == DW);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_y));

    assert_reset_R6: assert property (@(posedge clk)
        rst |=> (!out_valid && out_y == '0));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(out_y) <= PEAK && $signed(out_y) >= -PEAK));

endmodule

bind da_fir9 da_fir9_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .busy      (busy_w),
    .out_valid (out_valid),
    .out_y     (out_y)
);

// File: tb/sim_da_fir9.sv
module sim_da_fir9;
    import da_fir_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [DW-1:0]    in_sample = '0;
    logic             hp_sel = 1'b0;
    logic             out_valid;
    logic [ACC_W-1:0] out_y;

    da_fir9 u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .hp_sel    (hp_sel),
        .out_valid (out_valid),
        .out_y     (out_y)
    );

    int checks = 0;
    int errors = 0;
    int lp [9] = '{3, 10, 26, 44, 52, 44, 26, 10, 3};
    int hp [9] = '{3, -10, 26, -44, 52, -44, 26, -10, 3};
    int hist [9];
    int m_busy = 0, m_cnt = 0, m_y = 0, m_v = 0, m_pend = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int dot(bit s);
        int acc = 0;
        for (int k = 0; k < 9; k++) acc += (s ? hp[k] : lp[k]) * hist[k];
        return acc;
    endfunction

    // compare outputs of the last edge, drive inputs, advance model over the next edge
    task automatic tick(bit v, int d, bit s, bit r);
        check("R4 out_valid", int'(out_valid), m_v);
        if (m_v != 0) check("R1 result", int'($signed(out_y)), m_y);
        else          check("R7 hold", int'($signed(out_y)), m_y);
        rst = r; in_valid = v; in_sample = DW'(d); hp_sel = s;
        if (r) begin
            for (int k = 0; k < 9; k++) hist[k] = 0;
            m_busy = 0; m_cnt = 0; m_y = 0; m_v = 0;
        end else begin
            m_v = 0;
            if (m_busy != 0) begin
                m_cnt++;
                if (m_cnt == DW) begin
                    m_busy = 0; m_v = 1; m_y = m_pend;
                end
            end else if (v) begin
                for (int k = 8; k > 0; k--) hist[k] = hist[k-1];
                hist[0] = d;
                m_pend = dot(s);
                m_busy = 1; m_cnt = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic send(int d, bit s, bit nv, int nd, bit bs);
        tick(1'b1, d, s, 1'b0);
        for (int i = 0; i < DW; i++) tick(nv, nd, bs, 1'b0);
    endtask

    task automatic do_reset();
        tick(1'b0, 0, 1'b0, 1'b1);
        tick(1'b0, 0, 1'b0, 1'b1);
        tick(1'b0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 9; k++) hist[k] = 0;
        @(negedge clk);
        do_reset();
        check("R6 reset valid", int'(out_valid), 0);
        check("R6 reset y", int'($signed(out_y)), 0);

        // R1 / R3 impulse responses, low-pass
        send(1, 1'b0, 1'b0, 0, 1'b0);
        check("R1 R3 lp tap0", int'($signed(out_y)), lp[0]);
        for (int k = 1; k < 9; k++) begin
            send(0, 1'b0, 1'b0, 0, 1'b0);
            check("R1 R3 lp tap", int'($signed(out_y)), lp[k]);
        end

        // R3 impulse response, high-pass
        do_reset();
        send(1, 1'b1, 1'b0, 0, 1'b1);
        check("R3 hp tap0", int'($signed(out_y)), hp[0]);
        for (int k = 1; k < 9; k++) begin
            send(0, 1'b1, 1'b0, 0, 1'b1);
            check("R3 hp tap", int'($signed(out_y)), hp[k]);
        end

        // R2 / R9 extremes
        do_reset();
        for (int i = 0; i < 9; i++) send(-128, 1'b0, 1'b0, 0, 1'b0);
        check("R2 R9 all -128", int'($signed(out_y)), -27904);
        for (int i = 0; i < 9; i++) send(127, 1'b0, 1'b0, 0, 1'b0);
        check("R9 all 127", int'($signed(out_y)), 27686);
        for (int k = 8; k >= 0; k--) send((k % 2 == 1) ? -128 : 127, 1'b1, 1'b0, 0, 1'b1);
        check("R2 R9 hp matched", int'($signed(out_y)), 27794);

        // R5 offer during computation is dropped
        do_reset();
        send(1, 1'b0, 1'b1, 100, 1'b0);
        check("R5 first", int'($signed(out_y)), 3);
        send(0, 1'b0, 1'b0, 0, 1'b0);
        check("R5 ignored offer", int'($signed(out_y)), 10);

        // R8 select change during computation
        do_reset();
        send(1, 1'b0, 1'b0, 0, 1'b1);
        check("R8 sel captured", int'($signed(out_y)), 3);
        send(0, 1'b1, 1'b0, 0, 1'b0);
        check("R8 sel next", int'($signed(out_y)), -10);

        // R6 reset mid-stream clears history
        send(90, 1'b0, 1'b0, 0, 1'b0);
        tick(1'b1, 50, 1'b0, 1'b0);
        tick(1'b0, 0, 1'b0, 1'b0);
        do_reset();
        check("R6 mid reset y", int'($signed(out_y)), 0);
        send(0, 1'b0, 1'b0, 0, 1'b0);
        check("R6 history cleared", int'($signed(out_y)), 0);

        // mixed stream checked against the model every clock (R1 R4 R5 R7)
        for (int i = 0; i < 80; i++) begin
            int gap;
            gap = int'($urandom_range(0, 3));
            tick(1'b1, int'($urandom_range(0, 255)) - 128, 1'(i % 3 == 0), 1'b0);
            for (int j = 0; j < DW + gap; j++)
                tick(1'($urandom_range(0, 1)), int'($urandom_range(0, 255)) - 128,
                     1'($urandom_range(0, 1)), 1'b0);
        end
        tick(1'b0, 0, 1'b0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule